// File: doc/BRIEF.md
# Dual 8-bit Pulse Width Modulator with 16-bit Pairing

The block produces two pulse-width-modulated outputs from two independent channels. Each channel has a period register, a duty register, an enable bit and a polarity bit. Each channel has a counter that runs from zero up to the period value and then wraps. The channel's output is asserted while the count is below the duty value. So a duty of zero never asserts the output, and a duty above the period asserts it for the whole cycle.

A pairing bit joins the two channels into one wide channel. The two period bytes then form a 16-bit period, and the two duty bytes form a 16-bit duty. The result drives the first output, and the second output rests at its inactive level.

Period and duty writes go into shadow registers. The counter adopts them only when it wraps, so a change made mid-cycle never shortens or stretches the running pulse. Software programs the block through a single-cycle write strobe with an address and a data byte.

Top module: `pwm_dual8`

## Requirements
- R1: After reset both outputs are low: every control bit is zero, so both channels are disabled with active-high polarity.
- R2: A write with `wr_en` high is stored at the rising clock edge. The address map is: 0 control, 1 period of channel 0, 2 duty of channel 0, 3 period of channel 1, 4 duty of channel 1. The control bits are: bit 0 enable of channel 0, bit 1 enable of channel 1, bit 2 polarity of channel 0, bit 3 polarity of channel 1, bit 4 pairing.
- R3: While a channel is disabled, its output equals its polarity bit, which is its inactive level. The output reaches that level in the cycle right after the control write.
- R4: An enabled channel with period P and duty D repeats every P+1 clocks. Its output is active for the first D clocks of each repetition, starting in the cycle right after the enabling control write.
- R5: A duty of 0 keeps the output inactive for the whole time. A duty greater than the period keeps it active for the whole time.
- R6: With the polarity bit at 1, the output is the inverse of the active-high waveform, and the active level is low.
- R7: Period and duty writes to a running channel do not change its output until the counter wraps. From the first cycle after the wrap, the new values apply.
- R8: With the pairing bit set, output 0 follows a 16-bit channel. Its period is {period of channel 1, period of channel 0}, its duty is {duty of channel 1, duty of channel 0}, and it is enabled by the channel 0 enable bit.
- R9: With the pairing bit set, output 1 stays at the level of channel 1's polarity bit.
- R10: Writes to one channel's registers leave the other channel's waveform unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CH_W (8) | Write data |
| pwm0_o | output | 1 | Output of channel 0, or of the paired 16-bit channel |
| pwm1_o | output | 1 | Output of channel 1 |

## Verification
With the default combinational output stage, the outputs change in the cycle right after the clock edge that stores a control write. That cycle is index 0 of the waveform, and each later clock advances the index by one. The stimulus writes period and duty while the channels are disabled, then enables them. It pushes the expected level of both outputs for each index into a queue, starting at the sample point right after the enable write. A monitor pops one entry at each falling edge, which keeps every comparison aligned to its index. For the shadow-register check, the bench counts exactly which index carries the wrap edge and expects the old values up to that index and the new values from the next one.

// File: rtl/pwm_dual8_pkg.sv
package pwm_dual8_pkg;

   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] A_BASE = 3'd1;

   localparam int CTRL_W = 5;

   typedef struct packed {
      logic       pair;
      logic [1:0] pol;
      logic [1:0] en;
   } ctrl_t;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
   import pwm_dual8_pkg::*;
#(
   parameter int CH_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [CH_W-1:0]       wr_data,
   output ctrl_t                 ctrl_o,
   output logic [1:0][CH_W-1:0]  per_o,
   output logic [1:0][CH_W-1:0]  duty_o
);

   generate
      if (CH_W < CTRL_W) begin : g_bad_width
         $error("pwm_regs: CH_W must hold the control byte");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_o <= '0;
      end else if (wr_en && wr_addr == A_CTRL) begin
         ctrl_o <= ctrl_t'(wr_data[CTRL_W-1:0]);
      end
   end

   for (genvar c = 0; c < 2; c++) begin : g_ch
      localparam logic [ADDR_W-1:0] A_PER  = A_BASE + ADDR_W'(2*c);
      localparam logic [ADDR_W-1:0] A_DUTY = A_BASE + ADDR_W'(2*c + 1);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            per_o[c]  <= '0;
            duty_o[c] <= '0;
         end else if (wr_en) begin
            if (wr_addr == A_PER)  per_o[c]  <= wr_data;
            if (wr_addr == A_DUTY) duty_o[c] <= wr_data;
         end
      end
   end

   assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_CTRL) |=> (ctrl_o == ctrl_t'($past(wr_data[CTRL_W-1:0]))))
      else $error("assert_ctrl_store_R2 failed");

endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
   parameter int W       = 8,
   parameter bit REG_OUT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         pol,
   input  logic [W-1:0] per_sh,
   input  logic [W-1:0] duty_sh,
   output logic         pwm_o
);

   generate
      if (W < 2) begin : g_bad_w
         $error("pwm_core: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt_q;
   logic [W-1:0] per_q;
   logic [W-1:0] duty_q;
   logic         wrap;
   logic         level;

   assign wrap  = (cnt_q == per_q);
   assign level = pol ^ (en && (cnt_q < duty_q));

   // Shadow values are adopted while idle and at each wrap.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         per_q  <= '0;
         duty_q <= '0;
      end else if (!en || wrap) begin
         cnt_q  <= '0;
         per_q  <= per_sh;
         duty_q <= duty_sh;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   generate
      if (REG_OUT) begin : g_flop_out
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pwm_o <= 1'b0;
            else        pwm_o <= level;
         end
      end else begin : g_comb_out
         assign pwm_o = level;

         assert property (@(posedge clk) disable iff (!rst_n)
            !en |-> (pwm_o == pol))
            else $error("assert_idle_level_R3 failed");

         assert property (@(posedge clk) disable iff (!rst_n)
            (en && duty_q == '0) |-> (pwm_o == pol))
            else $error("assert_zero_duty_R5 failed");
      end
   endgenerate

   assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (cnt_q <= per_q))
      else $error("assert_cnt_in_range_R4 failed");

   assert property (@(posedge clk) disable iff (!rst_n)
      (en && !wrap) |=> ($stable(duty_q) && $stable(per_q)))
      else $error("assert_shadow_hold_R7 failed");

endmodule

// File: rtl/pwm_dual8.sv
module pwm_dual8
   import pwm_dual8_pkg::*;
#(
   parameter int CH_W    = 8,
   parameter bit REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CH_W-1:0]   wr_data,
   output logic              pwm0_o,
   output logic              pwm1_o
);

   localparam int WIDE_W = 2 * CH_W;

   ctrl_t                ctrl;
   logic [1:0][CH_W-1:0] per;
   logic [1:0][CH_W-1:0] duty;
   logic [1:0]           ch_out;
   logic                 wide_out;

   pwm_regs #(.CH_W(CH_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .ctrl_o  (ctrl),
      .per_o   (per),
      .duty_o  (duty)
   );

   for (genvar c = 0; c < 2; c++) begin : g_narrow
      pwm_core #(.W(CH_W), .REG_OUT(REG_OUT)) u_core (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (ctrl.en[c] && !ctrl.pair),
         .pol     (ctrl.pol[c]),
         .per_sh  (per[c]),
         .duty_sh (duty[c]),
         .pwm_o   (ch_out[c])
      );
   end

   pwm_core #(.W(WIDE_W), .REG_OUT(REG_OUT)) u_wide (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (ctrl.en[0] && ctrl.pair),
      .pol     (ctrl.pol[0]),
      .per_sh  ({per[1], per[0]}),
      .duty_sh ({duty[1], duty[0]}),
      .pwm_o   (wide_out)
   );

   assign pwm0_o = ctrl.pair ? wide_out     : ch_out[0];
   assign pwm1_o = ctrl.pair ? ctrl.pol[1]  : ch_out[1];

   generate
      if (!REG_OUT) begin : g_top_chk
         assert property (@(posedge clk) disable iff (!rst_n)
            ctrl.pair |-> (ch_out[1] == ctrl.pol[1]))
            else $error("assert_pair_idle_R9 failed");

         assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl.pair && !ctrl.en[0]) |-> (pwm0_o == ctrl.pol[0]))
            else $error("assert_pair_off_R8 failed");
      end
   endgenerate

endmodule

// File: tb/pwm_dual8_bench.sv
`timescale 1ns/1ps
module pwm_dual8_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       pwm0_o;
   logic       pwm1_o;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic  e0;
      logic  e1;
      string tag;
   } exp_t;

   exp_t q[$];

   always #2.5 clk = ~clk;

   pwm_dual8 u_pwm_dual8 (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .pwm0_o  (pwm0_o),
      .pwm1_o  (pwm1_o)
   );

   function automatic logic lvl(int i, int p, int d, logic pol);
      return pol ^ ((i % (p + 1)) < d);
   endfunction

   task automatic chk(input logic got, input logic exp, input string tag);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic push(input logic e0, input logic e1, input string tag);
      exp_t it;
      it.e0 = e0; it.e1 = e1; it.tag = tag;
      q.push_back(it);
   endtask

   // Monitor: one expected entry per falling edge.
   always begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
         exp_t it;
         it = q.pop_front();
         chk(pwm0_o, it.e0, {it.tag, " out0"});
         chk(pwm1_o, it.e1, {it.tag, " out1"});
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pwm0_o, 1'b0, "R1 out0");
      chk(pwm1_o, 1'b0, "R1 out1");

      // R3 / R2: both disabled, polarity bits set.
      wr(3'd0, 8'h0C);
      chk(pwm0_o, 1'b1, "R3 out0 idle");
      chk(pwm1_o, 1'b1, "R3 out1 idle");

      // R4 and R10: two independent periods.
      wr(3'd0, 8'h00);
      wr(3'd1, 8'd9); wr(3'd2, 8'd3);
      wr(3'd3, 8'd4); wr(3'd4, 8'd2);
      wr(3'd0, 8'h03);
      for (int i = 0; i < 40; i++) push(lvl(i, 9, 3, 0), lvl(i, 4, 2, 0), "R4/R10");
      repeat (40) @(negedge clk);

      // R5: duty 0 and duty above period.
      wr(3'd0, 8'h00);
      wr(3'd2, 8'd0);
      wr(3'd3, 8'd5); wr(3'd4, 8'd200);
      wr(3'd0, 8'h03);
      for (int i = 0; i < 30; i++) push(1'b0, 1'b1, "R5");
      repeat (30) @(negedge clk);

      // R6: inverted polarity.
      wr(3'd0, 8'h00);
      wr(3'd1, 8'd7); wr(3'd2, 8'd2);
      wr(3'd3, 8'd3); wr(3'd4, 8'd4);
      wr(3'd0, 8'h0F);
      for (int i = 0; i < 32; i++) push(lvl(i, 7, 2, 1), lvl(i, 3, 4, 1), "R6");
      repeat (32) @(negedge clk);

      // R7: mid-cycle update waits for the wrap edge between index 9 and 10.
      wr(3'd0, 8'h00);
      wr(3'd1, 8'd9); wr(3'd2, 8'd3);
      wr(3'd3, 8'd4); wr(3'd4, 8'd2);
      wr(3'd0, 8'h03);
      for (int i = 0; i < 5; i++) push(lvl(i, 9, 3, 0), lvl(i, 4, 2, 0), "R7");
      repeat (5) @(negedge clk);
      wr(3'd2, 8'd11);
      wr(3'd1, 8'd12);
      for (int i = 9; i < 34; i++) begin
         logic e0;
         e0 = (i < 10) ? lvl(i, 9, 3, 0) : lvl(i - 10, 12, 11, 0);
         push(e0, lvl(i, 4, 2, 0), "R7/R10");
      end
      repeat (25) @(negedge clk);

      // R3: disabling a running channel.
      wr(3'd0, 8'h02);
      chk(pwm0_o, 1'b0, "R3 out0 disabled mid-run");

      // R8 / R9: paired 16-bit channel, period 258, duty 128.
      wr(3'd0, 8'h00);
      wr(3'd1, 8'd2); wr(3'd3, 8'd1);
      wr(3'd2, 8'd128); wr(3'd4, 8'd0);
      wr(3'd0, 8'h19);
      for (int i = 0; i < 520; i++) push(lvl(i, 258, 128, 0), 1'b1, "R8/R9");
      repeat (520) @(negedge clk);

      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule